// File: doc/BRIEF.md
# Single-Wire Bus Bit-Slot Master

This block runs one time slot on an open-drain single-wire bus as the bus master. One slot both writes and reads. A one-cycle start request and a data bit begin the slot. When the bit is 0, the master holds the line low for most of the slot. When the bit is 1, the master pulls the line low only briefly and then releases it, so the same slot also serves as a read slot in which a slave can hold the line low. The block never drives the line high. It asserts an output enable that pulls the line low, and it drops that enable to let the external pull-up raise the bus.

The slot timing comes from a packed record of 16-bit microsecond values on an input port. A prescaler turns the system clock into microsecond ticks. One down-counter times each phase of the slot in turn. The bus input passes through a synchronizer and is sampled at the master-sample point. The sampled bit is reported with a one-cycle done pulse, but only after the recovery time at the end of the slot has passed. Reset and presence sequencing, byte framing and search algorithms are left to the logic that issues the slots.

Top module: `owslot_engine`

## Requirements
- R1: `timing_i` is 96 bits wide and holds six 16-bit unsigned microsecond fields. From the MSB down they are: reset-low [95:80], presence-sample [79:64], zero-low [63:48], one-low [47:32], sample-point [31:16] and slot length [15:0]. The first two fields are not used by this block.
- R2: A phase of D microseconds lasts D*PRESCALE clock cycles. A phase of 0 microseconds adds no tick wait and passes in a single clock cycle.
- R3: When `bit_i`=1, `bus_oe_o` is 1 for the one-low phase. The line is then released for a wait of (sample-point − one-low) phase and a recovery of (slot − sample-point) phase.
- R4: When `bit_i`=0, `bus_oe_o` stays 1 through a sample-point phase and then a (zero-low − sample-point) phase. The line is then released for a recovery of (slot − zero-low) phase.
- R5: The line is sampled at the end of the wait phase for a 1 slot, or at the end of the first low phase for a 0 slot. The sample is taken after a two-flop synchronizer. The returned bit is 1 only if the sampled line was high, and 0 otherwise.
- R6: `rbit_o` changes only in the cycle in which `done_o` is 1, which comes after the recovery phase. At all other times it holds its value.
- R7: `done_o` is 1 for exactly one cycle per slot, in the cycle after the last phase ends. `busy_o` is 1 from the cycle after an accepted start until that point.
- R8: A `start_i` that arrives while `busy_o` is 1 is ignored. It changes neither the slot in progress nor the outputs.
- R9: A phase length that would be negative after subtraction is clamped to 0 microseconds.
- R10: After reset, `bus_oe_o`, `busy_o`, `done_o` and `rbit_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a slot when the block is idle |
| bit_i | input | 1 | Bit to send; 1 also makes the slot a read slot |
| timing_i | input | 96 | Packed microsecond timing record (R1) |
| bus_i | input | 1 | Level of the bus line |
| bus_oe_o | output | 1 | 1 pulls the line low; 0 releases it |
| busy_o | output | 1 | A slot is in progress |
| done_o | output | 1 | One-cycle end-of-slot pulse |
| rbit_o | output | 1 | Bit sampled in the last slot |

## Verification
Random slots mix bit values and slave responses over timing records that meet the ordering assumptions. Write-1 slots with a slave that releases the line separate the sample point from the low pulse, while slots with a slave that holds the line low show that a low read is returned. Write-0 slots confirm that a held-low line always reads 0 and that the low time spans two phases. Directed records cover zero-length phases, clamped negative phases and a start pulse issued mid-slot, which separate the one-cycle zero phase, the saturation and the busy lockout from the normal timing.

// File: rtl/owslot_pkg.sv
package owslot_pkg;
  localparam int FIELD_W = 16;
  localparam int NUM_FIELDS = 6;
  localparam int TIMES_W = FIELD_W * NUM_FIELDS;

  typedef struct packed {
    logic [FIELD_W-1:0] rst_low;
    logic [FIELD_W-1:0] pres_smp;
    logic [FIELD_W-1:0] low0;
    logic [FIELD_W-1:0] low1;
    logic [FIELD_W-1:0] smp;
    logic [FIELD_W-1:0] slot;
  } owslot_times_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOW1  = 3'd1,
    ST_WAIT1 = 3'd2,
    ST_LOW0A = 3'd3,
    ST_LOW0B = 3'd4,
    ST_REC   = 3'd5
  } owslot_state_e;
endpackage

// File: rtl/owslot_tick.sv
module owslot_tick #(
  parameter int PRESCALE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  generate
    if (PRESCALE <= 1) begin : g_direct
      assign tick = 1'b1;
    end else begin : g_div
      logic [PW-1:0] pre_q, pre_d;

      always_comb begin
        if (restart || pre_q == LAST) pre_d = '0;
        else                          pre_d = pre_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
      end

      assign tick = (pre_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/owslot_sync.sv
module owslot_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/owslot_timer.sv
module owslot_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic         last
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                       cnt_d = load_val;
    else if (tick && cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // phase ends now: already empty, or the final tick arrives this cycle
  assign last = (cnt_q == '0) || (tick && cnt_q == W'(1));
endmodule

// File: rtl/owslot_engine.sv
module owslot_engine
  import owslot_pkg::*;
#(
  parameter int PRESCALE    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               bit_i,
  input  logic [TIMES_W-1:0] timing_i,
  input  logic               bus_i,
  output logic               bus_oe_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               rbit_o
);
  owslot_times_t      tm;
  owslot_state_e      state_q, state_d;
  logic [FIELD_W-1:0] dur_d;
  logic               load, last, tick, line_s;
  logic               smp_en, smp_q, done_d, done_q, rbit_q;

  assign tm = owslot_times_t'(timing_i);

  function automatic logic [FIELD_W-1:0] sat_sub(input logic [FIELD_W-1:0] a,
                                                  input logic [FIELD_W-1:0] b);
    return (a > b) ? (a - b) : '0;
  endfunction

  owslot_tick #(.PRESCALE(PRESCALE)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(load), .tick(tick)
  );

  owslot_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(bus_i), .q_o(line_s)
  );

  owslot_timer #(.W(FIELD_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(dur_d),
    .tick(tick), .last(last)
  );

  always_comb begin
    state_d = state_q;
    dur_d   = '0;
    load    = 1'b0;
    case (state_q)
      ST_IDLE: if (start_i) begin
        load = 1'b1;
        if (bit_i) begin state_d = ST_LOW1;  dur_d = tm.low1; end
        else       begin state_d = ST_LOW0A; dur_d = tm.smp;  end
      end
      ST_LOW1: if (last) begin
        load = 1'b1; state_d = ST_WAIT1; dur_d = sat_sub(tm.smp, tm.low1);
      end
      ST_WAIT1: if (last) begin
        load = 1'b1; state_d = ST_REC; dur_d = sat_sub(tm.slot, tm.smp);
      end
      ST_LOW0A: if (last) begin
        load = 1'b1; state_d = ST_LOW0B; dur_d = sat_sub(tm.low0, tm.smp);
      end
      ST_LOW0B: if (last) begin
        load = 1'b1; state_d = ST_REC; dur_d = sat_sub(tm.slot, tm.low0);
      end
      ST_REC: if (last) begin
        load = 1'b1; state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign smp_en = last && (state_q == ST_WAIT1 || state_q == ST_LOW0A);
  assign done_d = last && (state_q == ST_REC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      smp_q <= 1'b0;
    else if (smp_en) smp_q <= line_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rbit_q <= 1'b0;
    else if (done_d) rbit_q <= smp_q;
  end

  assign bus_oe_o = (state_q == ST_LOW1) || (state_q == ST_LOW0A) ||
                    (state_q == ST_LOW0B);
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign rbit_o   = rbit_q;
endmodule

// File: rtl/owslot_chk.sv
module owslot_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic bus_oe_o,
  input logic busy_o,
  input logic done_o,
  input logic rbit_o
);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  // R6
  rbit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(rbit_o));

  // R3
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !bus_oe_o);

  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> (busy_o || done_o));
endmodule

bind owslot_engine owslot_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .bus_oe_o(bus_oe_o),
  .busy_o(busy_o), .done_o(done_o), .rbit_o(rbit_o)
);

// File: tb/sim_owslot_engine.sv
module sim_owslot_engine;
  import owslot_pkg::*;
  localparam int P = 4;

  logic clk, rst_n, start_i, bit_i, bus_oe_o, busy_o, done_o, rbit_o;
  logic slave_bit;
  logic bus_i;
  owslot_times_t tm;
  int n_chk, n_fail;

  assign bus_i = slave_bit & ~bus_oe_o;

  owslot_engine #(.PRESCALE(P), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .bit_i(bit_i),
    .timing_i(tm), .bus_i(bus_i), .bus_oe_o(bus_oe_o), .busy_o(busy_o),
    .done_o(done_o), .rbit_o(rbit_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cyc(input int d);
    return (d == 0) ? 1 : d * P;
  endfunction

  function automatic int sub0(input int a, input int b);
    return (a > b) ? a - b : 0;
  endfunction

  task automatic run_slot(input logic b, input int w0, input int w1, input int ms,
                          input int sl, input logic slv, input logic poke);
    int lowc, tot, exp_low, exp_tot, exp_bit, n;
    logic timed_out;
    tm.rst_low = 16'd480; tm.pres_smp = 16'd70;
    tm.low0 = 16'(w0); tm.low1 = 16'(w1); tm.smp = 16'(ms); tm.slot = 16'(sl);
    slave_bit = slv;
    @(negedge clk); @(negedge clk); @(negedge clk);
    bit_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    n = 1; lowc = 0; timed_out = 1'b0;
    while (!done_o) begin
      if (bus_oe_o) lowc++;
      if (poke && n == 3) begin bit_i = ~b; start_i = 1'b1; end
      else start_i = 1'b0;
      @(negedge clk);
      n++;
      if (n > 20000) begin timed_out = 1'b1; break; end
    end
    start_i = 1'b0;
    tot = n;
    if (b) begin
      exp_low = cyc(w1);
      exp_tot = cyc(w1) + cyc(sub0(ms, w1)) + cyc(sub0(sl, ms)) + 1;
      exp_bit = (cyc(sub0(ms, w1)) >= 3) ? int'(slv) : 0;
    end else begin
      exp_low = cyc(ms) + cyc(sub0(w0, ms));
      exp_tot = exp_low + cyc(sub0(sl, w0)) + 1;
      exp_bit = (cyc(ms) >= 3) ? 0 : int'(slv);
    end
    check(!timed_out, "R7 watchdog per slot", int'(timed_out), 0);
    check(lowc == exp_low, b ? "R3 low time" : "R4 low time", lowc, exp_low);
    check(tot == exp_tot, "R2 R9 slot length", tot, exp_tot);
    check(int'(rbit_o) == exp_bit, "R5 R6 returned bit", int'(rbit_o), exp_bit);
    @(negedge clk);
    check(!done_o && !busy_o, "R7 done single cycle", int'(done_o), 0);
    check(int'(rbit_o) == exp_bit, "R6 bit held", int'(rbit_o), exp_bit);
    slave_bit = 1'b1;
  endtask

  initial begin
    int seed, w1, ms, w0, sl;
    n_chk = 0; n_fail = 0;
    seed = $urandom(32'h1A2B);
    rst_n = 1'b0; start_i = 1'b0; bit_i = 1'b0; slave_bit = 1'b1;
    tm = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!bus_oe_o && !busy_o && !done_o && !rbit_o, "R10 reset outputs",
          int'({bus_oe_o, busy_o, done_o, rbit_o}), 0);
    rst_n = 1'b1;
    // R1 field layout, R3/R4 directed nominal slots
    run_slot(1'b1, 60, 6, 15, 65, 1'b1, 1'b0);
    run_slot(1'b1, 60, 6, 15, 65, 1'b0, 1'b0);
    run_slot(1'b0, 60, 6, 15, 65, 1'b1, 1'b0);
    // R2 zero phases: one-low 0, zero-low == sample-point, slot == sample-point
    run_slot(1'b1, 5, 0, 5, 5, 1'b1, 1'b0);
    run_slot(1'b0, 5, 1, 5, 5, 1'b1, 1'b0);
    // R9 clamp: slot shorter than sample-point and zero-low
    run_slot(1'b1, 9, 2, 7, 3, 1'b1, 1'b0);
    run_slot(1'b0, 9, 2, 7, 3, 1'b0, 1'b0);
    // R8 start during busy ignored
    run_slot(1'b1, 8, 2, 6, 10, 1'b1, 1'b1);
    run_slot(1'b0, 8, 2, 6, 10, 1'b1, 1'b1);
    for (int i = 0; i < 40; i++) begin
      w1 = int'($urandom_range(0, 5));
      ms = w1 + int'($urandom_range(1, 6));
      w0 = ms + int'($urandom_range(0, 10));
      sl = w0 + int'($urandom_range(0, 10));
      run_slot(1'($urandom_range(0, 1)), w0, w1, ms, sl,
               1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R7 global watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule